// File: doc/BRIEF.md
# Latched serial-to-parallel output expander

The block turns a one-bit serial stream into a parallel word. Bits enter a chain of `W` flip-flops on each rising edge of a dedicated shift clock. A holding register, driven by its own storage clock, captures a snapshot of the whole chain. That snapshot drives the parallel outputs. The update of the outputs is therefore decoupled from the shifting: a controller can stream a new word in while the old one stays visible, then commit it with one storage-clock edge.

An active-low clear empties the shift chain at once, with no clock needed. It leaves the holding register alone. A disable input turns off the parallel outputs, which are modelled as a data bus plus a shared drive enable. The last chain stage is always presented on a cascade pin, which is meant to feed the serial input of the next instance. Several instances sharing both clocks thus act as one longer register.

Top module: `sipo_latch_expander`

## Requirements
- R1: On each rising edge of `store_clk`, the holding register takes all `W` shift-stage values in parallel, as they stood just before that edge.
- R2: The two clocks are independent. Shift edges alone leave the parallel outputs unchanged. Storage edges alone leave the shift chain, and so `cascade_out`, unchanged.
- R3: On a rising edge of `shift_clk`, stage 0 loads `ser_in` and stage i loads stage i-1. Stage i is presented on `par_data[i]`, so the most recent bit lands on bit 0.
- R4: A low `clear_n` forces every shift stage to 0 immediately and blocks shifting for as long as it is low. The holding register keeps its contents.
- R5: With `out_disable` high, `par_en` is 0 and `par_data` reads all zeros. With it low, `par_en` is 1 and `par_data` equals the holding register.
- R6: `cascade_out` always equals the last stage (W-1), whatever the state of `out_disable`. A bit appears there after exactly W shift edges.
- R7: With both clocks driven from one signal, each edge stores the chain state that existed before that same edge.
- R8: A storage edge taken while `clear_n` is still low loads all zeros into the holding register.
- R9: Before the first storage edge, the holding register holds the parameter `HOLD_INIT`, which defaults to all zeros.
- R10: Two instances linked cascade-to-serial-input, with shared clocks, behave as a 2W-bit register: after 2W shifts and one storage edge, their 16 outputs show the 16 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Rising-edge clock of the shift chain |
| store_clk | input | 1 | Rising-edge clock of the holding register |
| clear_n | input | 1 | Asynchronous active-low clear of the shift chain |
| out_disable | input | 1 | High turns the parallel outputs off |
| ser_in | input | 1 | Serial data into stage 0 |
| par_data | output | W (8) | Holding-register contents, zero while disabled |
| par_en | output | 1 | Drive enable shared by all parallel outputs |
| cascade_out | output | 1 | Last shift stage, always driven |

## Verification
Three events can coincide: a shift edge and a storage edge in the same instant, and either of them landing while the clear is held low. The bench ties both clocks together for runs of edges. It also fires storage and shift pulses while the clear is held low. It judges the results with a bench-side model that applies the storage copy before the shift, and treats a held clear as forcing zeros and blocking shifts. Randomly mixed operations on two chained instances put the same coincidences at many points in the data stream.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int unsigned SIPO_W_DEF = 8;

    // Parallel-bus value presented while the outputs are switched off.
    function automatic logic [SIPO_W_DEF-1:0] idle_bus();
        return '0;
    endfunction
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned W = 8
) (
    input  logic         shift_clk,
    input  logic         clear_n,
    input  logic         ser_in,
    output logic [W-1:0] stages
);
    typedef struct packed {
        logic [W-1:0] stg;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d.stg[0] = ser_in;
        for (int i = 1; i < int'(W); i++) begin
            chain_d.stg[i] = chain_q.stg[i-1];
        end
    end

    always_ff @(posedge shift_clk or negedge clear_n) begin
        if (!clear_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign stages = chain_q.stg;
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] HOLD_INIT = '0
) (
    input  logic         store_clk,
    input  logic [W-1:0] snap_in,
    output logic [W-1:0] hold
);
    typedef struct packed {
        logic [W-1:0] val;
    } hold_t;

    hold_t hold_d;
    hold_t hold_q = hold_t'(HOLD_INIT);

    always_comb begin
        hold_d     = hold_q;
        hold_d.val = snap_in;
    end

    always_ff @(posedge store_clk) begin
        hold_q <= hold_d;
    end

    assign hold = hold_q.val;
endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage #(
    parameter int unsigned W = 8
) (
    input  logic         out_disable,
    input  logic [W-1:0] hold,
    output logic [W-1:0] par_data,
    output logic         par_en
);
    always_comb begin
        par_en   = !out_disable;
        par_data = out_disable ? '0 : hold;
    end
endmodule

// File: rtl/sipo_latch_expander.sv
module sipo_latch_expander #(
    parameter int unsigned W         = sipo_pkg::SIPO_W_DEF,
    parameter logic [W-1:0] HOLD_INIT = '0
) (
    input  logic         shift_clk,
    input  logic         store_clk,
    input  logic         clear_n,
    input  logic         out_disable,
    input  logic         ser_in,
    output logic [W-1:0] par_data,
    output logic         par_en,
    output logic         cascade_out
);
    localparam int unsigned LAST = W - 1;

    logic [W-1:0] stage_w;
    logic [W-1:0] hold_w;

    sipo_shift_chain #(.W(W)) u_chain (
        .shift_clk (shift_clk),
        .clear_n   (clear_n),
        .ser_in    (ser_in),
        .stages    (stage_w)
    );

    sipo_hold_reg #(.W(W), .HOLD_INIT(HOLD_INIT)) u_hold (
        .store_clk (store_clk),
        .snap_in   (stage_w),
        .hold      (hold_w)
    );

    sipo_out_stage #(.W(W)) u_out (
        .out_disable (out_disable),
        .hold        (hold_w),
        .par_data    (par_data),
        .par_en      (par_en)
    );

    assign cascade_out = stage_w[LAST];
endmodule

// File: rtl/sipo_latch_expander_chk.sv
module sipo_latch_expander_chk #(
    parameter int unsigned W = 8
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         clear_n,
    input logic         out_disable,
    input logic         ser_in,
    input logic [W-1:0] par_data,
    input logic         par_en,
    input logic         cascade_out,
    input logic [W-1:0] stages,
    input logic [W-1:0] hold
);
    // Set by a clear, dropped on the next shift edge: marks windows in
    // which the one-edge history of the chain is not meaningful.
    logic clr_since = 1'b1;

    always_ff @(posedge shift_clk or negedge clear_n) begin
        if (!clear_n) begin
            clr_since <= 1'b1;
        end else begin
            clr_since <= 1'b0;
        end
    end

    p_shift_r3: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !clr_since |-> (stages[0] == $past(ser_in)) &&
                       (stages[W-1:1] == $past(stages[W-2:0])));

    p_cascade_r6: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !clr_since |-> cascade_out == $past(stages[W-2]));

    p_store_r1: assert property (@(posedge store_clk)
        1'b1 |=> hold == $past(stages));

    p_clear_store_r8: assert property (@(posedge store_clk)
        !clear_n |=> hold == '0);

    p_drive_r5: assert property (@(posedge store_clk)
        par_en |-> par_data == hold);

    p_off_r5: assert property (@(posedge shift_clk)
        out_disable |-> (!par_en && par_data == '0));
endmodule

bind sipo_latch_expander sipo_latch_expander_chk #(.W(W)) u_chk (
    .shift_clk   (shift_clk),
    .store_clk   (store_clk),
    .clear_n     (clear_n),
    .out_disable (out_disable),
    .ser_in      (ser_in),
    .par_data    (par_data),
    .par_en      (par_en),
    .cascade_out (cascade_out),
    .stages      (stage_w),
    .hold        (hold_w)
);

// File: tb/sipo_latch_expander_test.sv
`timescale 1ns/1ps
module sipo_latch_expander_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic sh_en = 1'b0, st_en = 1'b0;
    logic clear_n = 1'b0, out_disable = 1'b0, ser = 1'b0;
    logic shift_clk, store_clk;
    assign shift_clk = clk & sh_en;
    assign store_clk = clk & st_en;

    logic [7:0] pd0, pd1;
    logic pe0, pe1, casc0, casc1;

    sipo_latch_expander uut (
        .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
        .out_disable(out_disable), .ser_in(ser),
        .par_data(pd0), .par_en(pe0), .cascade_out(casc0));

    sipo_latch_expander uut_tail (
        .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
        .out_disable(out_disable), .ser_in(casc0),
        .par_data(pd1), .par_en(pe1), .cascade_out(casc1));

    int checks = 0, errors = 0;
    logic [7:0] m0 = '0, m1 = '0, h0 = '0, h1 = '0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] vis(input logic [7:0] h);
        return out_disable ? 8'h00 : h;
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " par"}, {pd1, pd0}, {vis(h1), vis(h0)});
        chk({tag, " en"}, {14'd0, pe1, pe0}, {14'd0, !out_disable, !out_disable});
        chk({tag, " cascade"}, {14'd0, casc1, casc0}, {14'd0, m1[7], m0[7]});
    endtask

    task automatic pulse(input bit sh, input bit st, input bit b);
        @(negedge clk);
        ser = b; sh_en = sh; st_en = st;
        @(posedge clk);
        if (st) begin h0 = m0; h1 = m1; end
        if (sh && clear_n) begin
            m1 = {m1[6:0], m0[7]};
            m0 = {m0[6:0], b};
        end
        @(negedge clk);
        sh_en = 1'b0; st_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        logic [15:0] word;
        int toggles;
        logic last_c;
        seed_dummy = $urandom(32'd577);

        // R9 R4: power-up hold value and cleared chain
        repeat (2) @(negedge clk);
        check_all("R9 R4 reset");
        clear_n = 1'b1;

        // R3 R6 R2: shift 16 known bits, outputs stay frozen
        word = 16'hA5C3;
        for (int i = 15; i >= 0; i--) begin
            pulse(1, 0, word[i]);
            check_all("R2 R6 shift");
        end
        // R1 R10: commit the full chained word
        pulse(0, 1, 1'b0);
        chk("R10 chained word", {pd1, pd0}, word);
        chk("R3 newest bit on bit0", {15'd0, pd0[0]}, {15'd0, word[0]});
        check_all("R1 store");

        // R2: storage edges alone do not move the chain
        pulse(0, 1, 1'b1);
        check_all("R2 store only");

        // R7: both clocks from one source
        for (int i = 0; i < 10; i++) begin
            pulse(1, 1, i[0] ^ i[2]);
            check_all("R7 tied clocks");
        end

        // R5 R6: disabled outputs, cascade keeps moving
        out_disable = 1'b1;
        toggles = 0;
        last_c = casc0;
        for (int i = 0; i < 12; i++) begin
            pulse(1, 0, i[0]);
            check_all("R5 R6 disabled");
            if (casc0 != last_c) toggles++;
            last_c = casc0;
        end
        chk("R6 cascade toggled", 16'(toggles > 4), 16'd1);
        pulse(0, 1, 1'b0);
        check_all("R5 store disabled");
        out_disable = 1'b0;
        #1 check_all("R5 re-enabled");

        // R4: clear mid-stream, hold kept, shifting blocked
        for (int i = 0; i < 8; i++) pulse(1, 0, 1'b1);
        pulse(0, 1, 1'b0);
        @(negedge clk);
        clear_n = 1'b0; m0 = '0; m1 = '0;
        #1 check_all("R4 clear async");
        pulse(1, 0, 1'b1);
        check_all("R4 shift blocked");
        // R8: storage edge while clear held
        pulse(0, 1, 1'b1);
        check_all("R8 store under clear");
        pulse(1, 1, 1'b1);
        check_all("R8 tied under clear");
        @(negedge clk);
        clear_n = 1'b1;

        // random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            if (op < 5) pulse(1, 0, 1'($urandom));
            else if (op < 7) pulse(0, 1, 1'b0);
            else if (op < 8) pulse(1, 1, 1'($urandom));
            else if (op < 9) begin
                @(negedge clk);
                out_disable = ~out_disable;
            end else begin
                @(negedge clk);
                clear_n = 1'b0; m0 = '0; m1 = '0;
                pulse(1, $urandom_range(0, 1) == 1, 1'b1);
                @(negedge clk);
                clear_n = 1'b1;
            end
            #1 check_all("R1 R3 R5 R6 R7 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule